// File: doc/BRIEF.md
# Two-Level DMA Channel Issue Scheduler

This block decides which DMA channel issues the next bus transfer. Each channel is ready when it is enabled, has an active transfer sequence, and its selected pacing request is asserted. The pacing request for each channel comes from a per-channel selector. The selector can pick a numbered data-request line, one of a small set of timer lines, or a request that is always asserted, for transfers that run unpaced.

Channels flagged high priority are served first. Each scheduling round grants every ready high-priority channel once, then grants a single ready low-priority channel, and then a new round starts. Inside each class, grants rotate by channel index. Each class keeps its own rotation pointer. The high-priority flag only changes the order in which channels issue; it does not touch bus priority. When the scheduler is not saturated, a low-priority channel loses nothing.

The grant is a registered one-hot vector with a valid flag. A grant that has been offered stays in place until the consumer raises `accept`. On that edge the next grant is computed from the ready vector at that edge.

Top module: `dma_issue_sched`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `grant_valid` is 0 and `grant` is all zeros. Both rotation pointers start so that channel 0 is the first candidate in each class.
- R2: While `grant_valid` is 1, `grant` has exactly one bit set. While `grant_valid` is 0, `grant` is zero.
- R3: A new grant is computed on a clock edge only when `grant_valid` is 0 or `accept` is 1. Otherwise `grant` and `grant_valid` hold their values.
- R4: Channel i is ready when `ch_enable[i]`, `ch_active[i]` and its selected request are all 1. A channel that is not ready is skipped, and it takes no slot in the round.
- R5: The request select for channel i is `ch_reqsel[i*6 +: 6]`. Values 0 to 58 pick `dreq_in[n]`. Values 59 to 62 pick `timer_in[n-59]`. Value 63 is always asserted.
- R6: In a round, every ready channel with `ch_hipri` set is granted once before one ready low-priority channel is granted. That low grant ends the round.
- R7: Inside a class, the next grant goes to the first ready channel above the last channel granted in that class, wrapping at the top index. Each class has its own pointer.
- R8: When no high-priority channel is ready, the low-priority channels are granted back to back in rotation order. When no low-priority channel is ready, the high-priority channels rotate with no break.
- R9: When no channel is ready at an edge where a new grant may be computed, `grant_valid` goes to 0 on that edge.
- R10: While a low-priority channel stays ready, fewer than NCH high-priority grants are issued in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | NCH | Per-channel enable |
| ch_active | input | NCH | Per-channel transfer sequence in progress |
| ch_hipri | input | NCH | Per-channel high-priority flag |
| ch_reqsel | input | NCH*6 | Per-channel pacing request select, 6 bits per channel |
| dreq_in | input | NDREQ | Numbered data-request lines |
| timer_in | input | NTIMER | Timer pacing lines |
| accept | input | 1 | The consumer takes the current grant |
| grant | output | NCH | One-hot registered grant |
| grant_valid | output | 1 | The grant is meaningful |

## Verification
If the served-set mask goes stale, a low-priority channel shows up too early or too late in the grant sequence. This becomes visible within a single round, so within one more grant than there are high-priority channels. If a rotation pointer is wrong or is shared between the classes, the grant sequence repeats or skips a channel on the second grant of that class. A fault in the request selector shows at once: a channel whose line is low appears in the grant sequence, or a channel whose line is high never appears. A broken hold condition shows up as a grant change in the first cycle that `accept` is low.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    localparam int unsigned SCH_NCH_DEF    = 8;
    localparam int unsigned SCH_SEL_W_DEF  = 6;
    localparam int unsigned SCH_NDREQ_DEF  = 59;
    localparam int unsigned SCH_NTIMER_DEF = 4;

    // Which candidate set produced the next grant
    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_HI     = 2'd1,
        PICK_LO     = 2'd2,
        PICK_HI_NEW = 2'd3
    } pick_src_e;

endpackage

// File: rtl/dma_req_select.sv
module dma_req_select #(
    parameter int unsigned SEL_W  = 6,
    parameter int unsigned NDREQ  = 59,
    parameter int unsigned NTIMER = 4
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [NDREQ-1:0]  dreq,
    input  logic [NTIMER-1:0] timer,
    output logic              req
);
    localparam int unsigned PERM_CODE  = (1 << SEL_W) - 1;
    localparam int unsigned TIMER_BASE = PERM_CODE - NTIMER;

    always_comb begin
        req = 1'b0;
        if (sel == SEL_W'(PERM_CODE)) begin
            req = 1'b1;
        end else begin
            for (int t = 0; t < int'(NTIMER); t++) begin
                if (sel == SEL_W'(TIMER_BASE + t)) req = timer[t];
            end
            for (int d = 0; d < int'(NDREQ); d++) begin
                if ((d < int'(TIMER_BASE)) && (sel == SEL_W'(d))) req = dreq[d];
            end
        end
    end
endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Search starts just above the last granted index and wraps
    always_comb begin
        gnt = '0;
        idx = last;
        any = 1'b0;
        for (int off = 1; off <= int'(N); off++) begin
            int c;
            c = int'(last) + off;
            if (c >= int'(N)) c = c - int'(N);
            if (!any && req[c]) begin
                any    = 1'b1;
                idx    = IW'(c);
                gnt[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_issue_sched.sv
module dma_issue_sched
    import dma_sched_pkg::*;
#(
    parameter int unsigned NCH    = SCH_NCH_DEF,
    parameter int unsigned SEL_W  = SCH_SEL_W_DEF,
    parameter int unsigned NDREQ  = SCH_NDREQ_DEF,
    parameter int unsigned NTIMER = SCH_NTIMER_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_enable,
    input  logic [NCH-1:0]       ch_active,
    input  logic [NCH-1:0]       ch_hipri,
    input  logic [NCH*SEL_W-1:0] ch_reqsel,
    input  logic [NDREQ-1:0]     dreq_in,
    input  logic [NTIMER-1:0]    timer_in,
    input  logic                 accept,
    output logic [NCH-1:0]       grant,
    output logic                 grant_valid
);
    localparam int unsigned IW        = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int unsigned PERM_CODE = (1 << SEL_W) - 1;
    localparam int unsigned STREAK_W  = $clog2(NCH + 1) + 1;

    typedef struct packed {
        logic [NCH-1:0] grant;
        logic           valid;
        logic [IW-1:0]  hi_last;
        logic [IW-1:0]  lo_last;
        logic [NCH-1:0] served;
    } sched_t;

    sched_t sch_d, sch_q;

    // ---------------- pacing request selection ----------------
    logic [NCH-1:0] treq_vec;
    logic [NCH-1:0] ready_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_req_select #(
            .SEL_W (SEL_W),
            .NDREQ (NDREQ),
            .NTIMER(NTIMER)
        ) u_sel (
            .sel  (ch_reqsel[g*SEL_W +: SEL_W]),
            .dreq (dreq_in),
            .timer(timer_in),
            .req  (treq_vec[g])
        );

        // an enabled, active channel with the permanent code is always ready
        AST_PERM_READY: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_enable[g] && ch_active[g] && ch_reqsel[g*SEL_W +: SEL_W] == SEL_W'(PERM_CODE))
            |-> ready_vec[g]); // R5
    end

    assign ready_vec = ch_enable & ch_active & treq_vec;

    // ---------------- candidate sets ----------------
    logic [NCH-1:0] hi_open_req, hi_all_req, lo_req;
    logic [NCH-1:0] hi_open_gnt, hi_all_gnt, lo_gnt;
    logic [IW-1:0]  hi_open_idx, hi_all_idx, lo_idx;
    logic           hi_open_any, hi_all_any, lo_any;

    assign hi_open_req = ready_vec & ch_hipri & ~sch_q.served;
    assign hi_all_req  = ready_vec & ch_hipri;
    assign lo_req      = ready_vec & ~ch_hipri;

    dma_rr_pick #(.N(NCH)) u_hi_open (
        .req (hi_open_req), .last(sch_q.hi_last),
        .gnt (hi_open_gnt), .idx (hi_open_idx), .any(hi_open_any)
    );
    dma_rr_pick #(.N(NCH)) u_hi_all (
        .req (hi_all_req), .last(sch_q.hi_last),
        .gnt (hi_all_gnt), .idx (hi_all_idx), .any(hi_all_any)
    );
    dma_rr_pick #(.N(NCH)) u_lo (
        .req (lo_req), .last(sch_q.lo_last),
        .gnt (lo_gnt), .idx (lo_idx), .any(lo_any)
    );

    pick_src_e pick_src;
    logic      issue_slot;

    assign issue_slot = !sch_q.valid || accept;

    always_comb begin
        if (hi_open_any)     pick_src = PICK_HI;
        else if (lo_any)     pick_src = PICK_LO;
        else if (hi_all_any) pick_src = PICK_HI_NEW;
        else                 pick_src = PICK_NONE;
    end

    // ---------------- next state ----------------
    always_comb begin
        sch_d = sch_q;
        if (issue_slot) begin
            unique case (pick_src)
                PICK_HI: begin
                    sch_d.grant   = hi_open_gnt;
                    sch_d.valid   = 1'b1;
                    sch_d.hi_last = hi_open_idx;
                    sch_d.served  = sch_q.served | hi_open_gnt;
                end
                PICK_LO: begin
                    sch_d.grant   = lo_gnt;
                    sch_d.valid   = 1'b1;
                    sch_d.lo_last = lo_idx;
                    sch_d.served  = '0;
                end
                PICK_HI_NEW: begin
                    sch_d.grant   = hi_all_gnt;
                    sch_d.valid   = 1'b1;
                    sch_d.hi_last = hi_all_idx;
                    sch_d.served  = hi_all_gnt;
                end
                default: begin
                    sch_d.grant  = '0;
                    sch_d.valid  = 1'b0;
                    sch_d.served = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sch_q.grant   <= '0;
            sch_q.valid   <= 1'b0;
            sch_q.hi_last <= IW'(NCH - 1);
            sch_q.lo_last <= IW'(NCH - 1);
            sch_q.served  <= '0;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign grant       = sch_q.grant;
    assign grant_valid = sch_q.valid;

    // ---------------- low-class starvation window ----------------
    logic [STREAK_W-1:0] hi_streak_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_streak_q <= '0;
        end else if (issue_slot) begin
            if (lo_req == '0 || pick_src == PICK_LO || pick_src == PICK_NONE)
                hi_streak_q <= '0;
            else
                hi_streak_q <= hi_streak_q + 1'b1;
        end
    end

    // ---------------- assertions ----------------
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!grant_valid && grant == '0)); // R1

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $onehot(grant)); // R2

    AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0)); // R2

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !accept) |=> (grant_valid && $stable(grant))); // R3

    AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_slot && ready_vec != '0) |=> (grant_valid && (grant & $past(ready_vec)) != '0)); // R4

    AST_EMPTY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_slot && ready_vec == '0) |=> !grant_valid); // R9

    AST_LOW_NOT_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
        hi_streak_q < STREAK_W'(NCH)); // R10

endmodule

// File: tb/tb_dma_issue_sched.sv
`timescale 1ns/1ps
module tb_dma_issue_sched;
    localparam int NCH = 8;
    localparam int SW  = 6;
    localparam int ND  = 59;
    localparam int NT  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    ch_enable = '0;
    logic [NCH-1:0]    ch_active = '0;
    logic [NCH-1:0]    ch_hipri = '0;
    logic [NCH*SW-1:0] ch_reqsel = '0;
    logic [ND-1:0]     dreq_in = '0;
    logic [NT-1:0]     timer_in = '0;
    logic              accept = 1'b0;
    logic [NCH-1:0]    grant;
    logic              grant_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_issue_sched #(.NCH(NCH), .SEL_W(SW), .NDREQ(ND), .NTIMER(NT)) dut (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_active(ch_active),
        .ch_hipri(ch_hipri), .ch_reqsel(ch_reqsel), .dreq_in(dreq_in),
        .timer_in(timer_in), .accept(accept), .grant(grant), .grant_valid(grant_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_sel(input int ch, input int code);
        ch_reqsel[ch*SW +: SW] = SW'(code);
    endtask

    task automatic clear_inputs();
        ch_enable = '0; ch_active = '0; ch_hipri = '0;
        ch_reqsel = '0; dreq_in = '0; timer_in = '0;
        accept = 1'b1;
    endtask

    // reset with current inputs, release at a falling edge
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // sample the grant issued at the next rising edge
    task automatic expect_grant(input string req, input int ch);
        @(posedge clk); #1;
        check(req, {31'd0, grant_valid}, 32'd1);
        check(req, 32'(grant), 32'(1 << ch));
    endtask

    task automatic test_reset();
        clear_inputs();
        ch_enable = '1; ch_active = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 63);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 valid in reset", {31'd0, grant_valid}, 32'd0);
        check("R1 grant in reset", 32'(grant), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        expect_grant("R1 first grant ch0", 0);
    endtask

    task automatic test_two_level();
        clear_inputs();
        ch_enable = '1; ch_active = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 63);
        ch_hipri = 8'b0101_0010; // 1,4,6 high
        do_reset();
        expect_grant("R6 r1 hi", 1);
        expect_grant("R6 r1 hi", 4);
        expect_grant("R6 r1 hi", 6);
        expect_grant("R6 r1 lo", 0);
        expect_grant("R7 r2 hi", 1);
        expect_grant("R7 r2 hi", 4);
        expect_grant("R7 r2 hi", 6);
        expect_grant("R7 r2 lo next", 2);
        expect_grant("R6 r3 hi", 1);
    endtask

    task automatic test_low_only();
        clear_inputs();
        ch_enable = 8'b1010_0100; ch_active = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 63);
        do_reset();
        expect_grant("R8 lo", 2);
        expect_grant("R8 lo", 5);
        expect_grant("R8 lo", 7);
        expect_grant("R8 lo wrap", 2);
    endtask

    task automatic test_hi_only();
        clear_inputs();
        ch_enable = 8'b0010_0100; ch_active = '1; ch_hipri = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 63);
        do_reset();
        expect_grant("R8 hi", 2);
        expect_grant("R8 hi", 5);
        expect_grant("R8 hi wrap", 2);
        expect_grant("R8 hi", 5);
    endtask

    task automatic test_req_select();
        clear_inputs();
        ch_enable = 8'b1111_1110; ch_active = 8'b1011_1111;
        set_sel(0, 63);                     // disabled
        set_sel(1, 60); timer_in[1] = 1'b1; // timer 1 high
        set_sel(2, 10); dreq_in[10] = 1'b1;
        set_sel(3, 5);                      // line 5 low
        set_sel(4, 58); dreq_in[58] = 1'b1; // top data line
        set_sel(5, 61);                     // timer 2 low
        set_sel(6, 63);                     // not active
        set_sel(7, 40);                     // line 40 low
        do_reset();
        expect_grant("R5 timer sel", 1);
        expect_grant("R5 dreq sel", 2);
        expect_grant("R4 skip low line", 4);
        expect_grant("R4 rotate", 1);
        @(negedge clk); timer_in[2] = 1'b1;
        expect_grant("R5 timer2 now high", 2);
        expect_grant("R4", 4);
        expect_grant("R5 timer2", 5);
    endtask

    task automatic test_hold();
        clear_inputs();
        ch_enable = 8'b0000_1001; ch_active = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 63);
        accept = 1'b0;
        do_reset();
        expect_grant("R3 first issue", 0);
        for (int k = 0; k < 3; k++) expect_grant("R3 held", 0);
        @(negedge clk); accept = 1'b1;
        expect_grant("R3 advance", 3);
    endtask

    task automatic test_empty();
        clear_inputs();
        ch_enable = '1; ch_active = '1;
        for (int c = 0; c < NCH; c++) set_sel(c, 3); // line 3 low
        do_reset();
        @(posedge clk); #1;
        check("R9 nothing ready valid", {31'd0, grant_valid}, 32'd0);
        check("R9 nothing ready grant", 32'(grant), 32'd0);
        @(negedge clk); dreq_in[3] = 1'b1;
        expect_grant("R9 line rises", 0);
        @(negedge clk); dreq_in[3] = 1'b0;
        @(posedge clk); #1;
        check("R9 drops again", {31'd0, grant_valid}, 32'd0);
    endtask

    task automatic test_starve();
        clear_inputs();
        ch_enable = '1; ch_active = '1; ch_hipri = 8'b1111_1110;
        for (int c = 0; c < NCH; c++) set_sel(c, 63);
        do_reset();
        for (int c = 1; c < NCH; c++) expect_grant("R10 hi run", c);
        expect_grant("R10 low served", 0);
        expect_grant("R6 new round", 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_two_level();
        test_low_only();
        test_hi_only();
        test_req_select();
        test_hold();
        test_empty();
        test_starve();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule